// File: doc/BRIEF.md
# Mixed-width true dual-port RAM

This block models a 9-kilobit embedded RAM with two independent ports, A and B. Each port has its own clock and may read or write in any cycle. Both ports can therefore do two reads, two writes, or one of each at the same time. Each port sees the same bit array at its own data width. The non-parity widths are 1, 2, 4, 8 and 16 bits over 8192 bits of storage, and any of them may be paired with any other. The parity widths are 9 and 18 bits over 9216 bits of storage, and they may only be paired with each other. Any other pairing of `WIDTH_A` and `WIDTH_B` stops elaboration with an error.

Every port samples its controls on the rising edge of its own clock. A write lands in storage at that edge. A read loads the registered output at that same edge, so read data appears one edge after the request. The parameter `NEW_ON_COLLIDE` sets what a port returns when it reads and writes one address in one cycle: the data being written (1) or the data stored before the write (0). When both ports write overlapping bits in the same cycle, the result at those bits is undefined.

Top module: `tdp_ram9k`

## Requirements
- R1: Word k of a port of width W occupies bits k*W to k*W+W-1 of the shared array. Data written through one port reads back through the other port at that port's width, with the lowest-numbered bits in the lowest word.
- R2: When clock enable is high and read enable is high at a rising edge, the output register loads the addressed word at that edge. When read enable is low, the output register keeps its value, even if the same cycle writes.
- R3: A cycle that reads and writes one address on one port returns the newly written data, merged with the byte enables, when `NEW_ON_COLLIDE`=1. It returns the previously stored word when `NEW_ON_COLLIDE`=0.
- R4: At widths 16 and 18, byte-enable bit i gates write-data bits i*L to i*L+L-1, where L=8 for width 16 and L=9 for width 18. Lanes whose enable bit is 0 keep their stored bits.
- R5: At widths below 16, the byte-enable bits are ignored and every write stores the whole word, including a write with byte enable 00.
- R6: While address stall is high, a port reads and writes at the address it latched most recently and ignores its address input. An edge with clock enable high and stall low latches a new address.
- R7: When clock enable is low at an edge, the port performs no write and leaves its output register and its latched address unchanged.
- R8: Asynchronous clear forces the port's output register to zero at once, without a clock edge. It leaves the stored contents unchanged.
- R9: The two ports run concurrently on their own clocks. Writes to distinct words by both ports in overlapping cycles both take effect, and a read on one port is unaffected by a write on the other port to a different word.
- R10: With the parity widths 18 and 9, all 9216 bits are addressable. Word j of the 9-bit port is bits 9j to 9j+8, so it holds the lower half of 18-bit word j/2 when j is even and the upper half when j is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| ce_a | input | 1 | Port A clock enable; low freezes port A |
| aclr_a | input | 1 | Port A asynchronous clear of the output register |
| we_a | input | 1 | Port A write enable |
| re_a | input | 1 | Port A read enable |
| stall_a | input | 1 | Port A address stall; holds the latched address |
| addr_a | input | log2(array bits / WIDTH_A) | Port A word address |
| din_a | input | WIDTH_A | Port A write data |
| be_a | input | 2 | Port A byte-lane write enables (widths 16/18 only) |
| dout_a | output | WIDTH_A | Port A registered read data |
| clk_b | input | 1 | Port B clock |
| ce_b | input | 1 | Port B clock enable |
| aclr_b | input | 1 | Port B asynchronous clear of the output register |
| we_b | input | 1 | Port B write enable |
| re_b | input | 1 | Port B read enable |
| stall_b | input | 1 | Port B address stall |
| addr_b | input | log2(array bits / WIDTH_B) | Port B word address |
| din_b | input | WIDTH_B | Port B write data |
| be_b | input | 2 | Port B byte-lane write enables (widths 16/18 only) |
| dout_b | output | WIDTH_B | Port B registered read data |

## Verification
The latched address is the hardest behaviour to observe from the ports. A disabled clock must leave it unchanged, but nothing shows its value unless a later access is made under stall. The stimulus first latches one address. It then applies an enabled-low cycle with a different address and read requested. A stalled read follows, and its data shows which address was kept. The idle cycles between operations keep stall high, so they do not disturb the latched address.

// File: rtl/tdp_ram9k.sv
module tdp_ram9k #(
  parameter int WIDTH_A = 16,
  parameter int WIDTH_B = 4,
  parameter bit NEW_ON_COLLIDE = 1'b1,
  localparam bit PAR_A = (WIDTH_A == 9) || (WIDTH_A == 18),
  localparam int TOTAL = PAR_A ? 9216 : 8192,
  localparam int AW_A = $clog2(TOTAL / WIDTH_A),
  localparam int AW_B = $clog2(TOTAL / WIDTH_B)
) (
  input  logic               clk_a,
  input  logic               ce_a,
  input  logic               aclr_a,
  input  logic               we_a,
  input  logic               re_a,
  input  logic               stall_a,
  input  logic [AW_A-1:0]    addr_a,
  input  logic [WIDTH_A-1:0] din_a,
  input  logic [1:0]         be_a,
  output logic [WIDTH_A-1:0] dout_a,
  input  logic               clk_b,
  input  logic               ce_b,
  input  logic               aclr_b,
  input  logic               we_b,
  input  logic               re_b,
  input  logic               stall_b,
  input  logic [AW_B-1:0]    addr_b,
  input  logic [WIDTH_B-1:0] din_b,
  input  logic [1:0]         be_b,
  output logic [WIDTH_B-1:0] dout_b
);

  localparam bit PAR_B = (WIDTH_B == 9) || (WIDTH_B == 18);
  localparam bit NP_A = (WIDTH_A == 1) || (WIDTH_A == 2) || (WIDTH_A == 4) ||
                        (WIDTH_A == 8) || (WIDTH_A == 16);
  localparam bit NP_B = (WIDTH_B == 1) || (WIDTH_B == 2) || (WIDTH_B == 4) ||
                        (WIDTH_B == 8) || (WIDTH_B == 16);
  localparam int LANE = PAR_A ? 9 : 8;
  localparam int IW = $clog2(TOTAL);

  if (!((NP_A && NP_B) || (PAR_A && PAR_B))) begin : g_bad_shape
    $error("tdp_ram9k: port widths %0d and %0d cannot share one array", WIDTH_A, WIDTH_B);
  end

  // Each bank has one writer; stored value is the XOR of the two.
  logic [TOTAL-1:0] bank_a, bank_b;

  logic [AW_A-1:0]    hold_a;
  logic [AW_A-1:0]    eff_a;
  logic [IW-1:0]      base_a;
  logic [WIDTH_A-1:0] mask_a, old_a, merged_a;

  logic [AW_B-1:0]    hold_b;
  logic [AW_B-1:0]    eff_b;
  logic [IW-1:0]      base_b;
  logic [WIDTH_B-1:0] mask_b, old_b, merged_b;

  wire unused_be = &{1'b0, be_a, be_b};

  assign eff_a    = stall_a ? hold_a : addr_a;
  assign base_a   = IW'(eff_a) * IW'(WIDTH_A);
  assign old_a    = bank_a[base_a +: WIDTH_A] ^ bank_b[base_a +: WIDTH_A];
  assign merged_a = (old_a & ~mask_a) | (din_a & mask_a);

  assign eff_b    = stall_b ? hold_b : addr_b;
  assign base_b   = IW'(eff_b) * IW'(WIDTH_B);
  assign old_b    = bank_a[base_b +: WIDTH_B] ^ bank_b[base_b +: WIDTH_B];
  assign merged_b = (old_b & ~mask_b) | (din_b & mask_b);

  for (genvar i = 0; i < WIDTH_A; i++) begin : g_mask_a
    if (WIDTH_A >= 16) begin : g_lane
      assign mask_a[i] = be_a[i / LANE];
    end else begin : g_full
      assign mask_a[i] = 1'b1;
    end
  end

  for (genvar i = 0; i < WIDTH_B; i++) begin : g_mask_b
    if (WIDTH_B >= 16) begin : g_lane
      assign mask_b[i] = be_b[i / LANE];
    end else begin : g_full
      assign mask_b[i] = 1'b1;
    end
  end

  always_ff @(posedge clk_a) begin
    if (ce_a) begin
      hold_a <= eff_a;
      if (we_a)
        bank_a[base_a +: WIDTH_A] <= (bank_a[base_a +: WIDTH_A] & ~mask_a) |
                                     ((din_a ^ bank_b[base_a +: WIDTH_A]) & mask_a);
    end
  end

  always_ff @(posedge clk_b) begin
    if (ce_b) begin
      hold_b <= eff_b;
      if (we_b)
        bank_b[base_b +: WIDTH_B] <= (bank_b[base_b +: WIDTH_B] & ~mask_b) |
                                     ((din_b ^ bank_a[base_b +: WIDTH_B]) & mask_b);
    end
  end

  always_ff @(posedge clk_a or posedge aclr_a) begin
    if (aclr_a)
      dout_a <= '0;
    else if (ce_a && re_a)
      dout_a <= (NEW_ON_COLLIDE && we_a) ? merged_a : old_a;
  end

  always_ff @(posedge clk_b or posedge aclr_b) begin
    if (aclr_b)
      dout_b <= '0;
    else if (ce_b && re_b)
      dout_b <= (NEW_ON_COLLIDE && we_b) ? merged_b : old_b;
  end

endmodule

// File: rtl/tdp_ram9k_chk.sv
module tdp_ram9k_chk #(
  parameter int WA = 16,
  parameter int WB = 4,
  parameter bit NEWD = 1'b1
) (
  input logic          clk_a,
  input logic          ce_a,
  input logic          aclr_a,
  input logic          we_a,
  input logic          re_a,
  input logic [1:0]    be_a,
  input logic [WA-1:0] din_a,
  input logic [WA-1:0] dout_a,
  input logic          clk_b,
  input logic          ce_b,
  input logic          aclr_b,
  input logic          we_b,
  input logic          re_b,
  input logic [1:0]    be_b,
  input logic [WB-1:0] din_b,
  input logic [WB-1:0] dout_b
);

  // R2
  hold_a_chk: assert property (@(posedge clk_a) disable iff (aclr_a)
    !(ce_a && re_a) |=> $stable(dout_a));

  // R2
  hold_b_chk: assert property (@(posedge clk_b) disable iff (aclr_b)
    !(ce_b && re_b) |=> $stable(dout_b));

  // R8
  clr_a_chk: assert property (@(posedge clk_a) aclr_a |-> dout_a == '0);

  // R8
  clr_b_chk: assert property (@(posedge clk_b) aclr_b |-> dout_b == '0);

  // R3
  newdata_a_chk: assert property (@(posedge clk_a) disable iff (aclr_a)
    (NEWD && ce_a && re_a && we_a && (WA < 16 || (&be_a))) |=> dout_a == $past(din_a));

  // R3
  newdata_b_chk: assert property (@(posedge clk_b) disable iff (aclr_b)
    (NEWD && ce_b && re_b && we_b && (WB < 16 || (&be_b))) |=> dout_b == $past(din_b));

endmodule

bind tdp_ram9k tdp_ram9k_chk #(.WA(WIDTH_A), .WB(WIDTH_B), .NEWD(NEW_ON_COLLIDE)) u_chk (
  .clk_a(clk_a), .ce_a(ce_a), .aclr_a(aclr_a), .we_a(we_a), .re_a(re_a),
  .be_a(be_a), .din_a(din_a), .dout_a(dout_a),
  .clk_b(clk_b), .ce_b(ce_b), .aclr_b(aclr_b), .we_b(we_b), .re_b(re_b),
  .be_b(be_b), .din_b(din_b), .dout_b(dout_b)
);

// File: tb/test_tdp_ram9k.sv
module test_tdp_ram9k;

  logic clk_a = 1'b0;
  logic clk_b;
  always #10 clk_a = ~clk_a;
  assign clk_b = ~clk_a;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic ce_a = 1, aclr_a = 0, we_a = 0, re_a = 0, st_a = 0;
  logic [8:0] ad_a = '0;
  logic [15:0] di_a = '0;
  logic [1:0] be_a = 2'b11;
  logic [15:0] do_a;
  logic ce_b = 1, aclr_b = 0, we_b = 0, re_b = 0, st_b = 0;
  logic [10:0] ad_b = '0;
  logic [3:0] di_b = '0;
  logic [1:0] be_b = 2'b11;
  logic [3:0] do_b;

  tdp_ram9k #(.WIDTH_A(16), .WIDTH_B(4), .NEW_ON_COLLIDE(1'b1)) i_tdp_ram9k (
    .clk_a(clk_a), .ce_a(ce_a), .aclr_a(aclr_a), .we_a(we_a), .re_a(re_a),
    .stall_a(st_a), .addr_a(ad_a), .din_a(di_a), .be_a(be_a), .dout_a(do_a),
    .clk_b(clk_b), .ce_b(ce_b), .aclr_b(aclr_b), .we_b(we_b), .re_b(re_b),
    .stall_b(st_b), .addr_b(ad_b), .din_b(di_b), .be_b(be_b), .dout_b(do_b));

  logic paclr = 0, pwe_a = 0, pre_a = 0, pre_b = 0;
  logic [8:0] pad_a = '0;
  logic [17:0] pdi_a = '0;
  logic [1:0] pbe_a = 2'b11;
  logic [17:0] pdo_a;
  logic [9:0] pad_b = '0;
  logic [8:0] pdo_b;

  tdp_ram9k #(.WIDTH_A(18), .WIDTH_B(9), .NEW_ON_COLLIDE(1'b0)) i_tdp_ram9k_par (
    .clk_a(clk_a), .ce_a(1'b1), .aclr_a(paclr), .we_a(pwe_a), .re_a(pre_a),
    .stall_a(1'b0), .addr_a(pad_a), .din_a(pdi_a), .be_a(pbe_a), .dout_a(pdo_a),
    .clk_b(clk_b), .ce_b(1'b1), .aclr_b(paclr), .we_b(1'b0), .re_b(pre_b),
    .stall_b(1'b0), .addr_b(pad_b), .din_b(9'd0), .be_b(2'b00), .dout_b(pdo_b));

  logic [8191:0] mdl;

  function automatic logic [15:0] fa(int k);
    return 16'((k * 40503) ^ 16'h5A5A);
  endfunction
  function automatic logic [3:0] gb(int j);
    return 4'(j * 7 + 3);
  endfunction
  function automatic logic [17:0] fp(int k);
    return 18'(k * 163841 + 77);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic opa(logic we, logic re, logic st, logic ce, logic [8:0] ad,
                     logic [15:0] d, logic [1:0] be);
    @(negedge clk_a);
    we_a = we; re_a = re; st_a = st; ce_a = ce; ad_a = ad; di_a = d; be_a = be;
    @(negedge clk_a);
    we_a = 0; re_a = 0; st_a = 1; ce_a = 1;
  endtask

  task automatic opb(logic we, logic re, logic st, logic ce, logic [10:0] ad,
                     logic [3:0] d, logic [1:0] be);
    @(negedge clk_b);
    we_b = we; re_b = re; st_b = st; ce_b = ce; ad_b = ad; di_b = d; be_b = be;
    @(negedge clk_b);
    we_b = 0; re_b = 0; st_b = 1; ce_b = 1;
  endtask

  task automatic mwa(int ad, logic [15:0] d, logic [1:0] be);
    for (int i = 0; i < 2; i++)
      if (be[i]) mdl[ad*16 + 8*i +: 8] = d[8*i +: 8];
  endtask

  task automatic ppa(logic we, logic re, logic [8:0] ad, logic [17:0] d, logic [1:0] be);
    @(negedge clk_a);
    pwe_a = we; pre_a = re; pad_a = ad; pdi_a = d; pbe_a = be;
    @(negedge clk_a);
    pwe_a = 0; pre_a = 0;
  endtask

  task automatic ppb(logic [9:0] ad);
    @(negedge clk_b);
    pre_b = 1; pad_b = ad;
    @(negedge clk_b);
    pre_b = 0;
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up();
    end
  end

  initial begin
    logic [15:0] w;
    logic [15:0] keep;
    #1;
    aclr_a = 1; aclr_b = 1; paclr = 1;
    repeat (3) @(negedge clk_a);
    chk("R8 reset A", 32'(do_a), 32'h0);
    chk("R8 reset B", 32'(do_b), 32'h0);
    chk("R8 reset parity A", 32'(pdo_a), 32'h0);
    aclr_a = 0; aclr_b = 0; paclr = 0;

    // R1: A writes all words, B reads every nibble
    for (int k = 0; k < 512; k++) begin
      opa(1, 0, 0, 1, 9'(k), fa(k), 2'b11);
      mwa(k, fa(k), 2'b11);
    end
    for (int j = 0; j < 2048; j++) begin
      opb(0, 1, 0, 1, 11'(j), 4'h0, 2'b00);
      chk("R1 A-to-B", 32'(do_b), 32'(mdl[j*4 +: 4]));
    end
    // R1: B writes nibbles, A reads words
    for (int j = 0; j < 256; j++) begin
      opb(1, 0, 0, 1, 11'(j), gb(j), 2'b00);
      mdl[j*4 +: 4] = gb(j);
    end
    for (int k = 0; k < 64; k++) begin
      opa(0, 1, 0, 1, 9'(k), 16'h0, 2'b00);
      chk("R1 B-to-A", 32'(do_a), 32'({gb(4*k+3), gb(4*k+2), gb(4*k+1), gb(4*k)}));
    end

    // R2
    opa(0, 1, 0, 1, 9'd5, 16'h0, 2'b00);
    keep = mdl[5*16 +: 16];
    chk("R2 read", 32'(do_a), 32'(keep));
    opa(0, 0, 0, 1, 9'd6, 16'h0, 2'b00);
    chk("R2 hold no read", 32'(do_a), 32'(keep));
    opa(1, 0, 0, 1, 9'd7, 16'h0F0F, 2'b11);
    mwa(7, 16'h0F0F, 2'b11);
    chk("R2 hold on write", 32'(do_a), 32'(keep));
    opa(0, 1, 0, 1, 9'd7, 16'h0, 2'b00);
    chk("R2 read back", 32'(do_a), 32'h0F0F);

    // R3 / R4
    opa(1, 1, 0, 1, 9'd10, 16'hBEEF, 2'b11);
    mwa(10, 16'hBEEF, 2'b11);
    chk("R3 new data A", 32'(do_a), 32'hBEEF);
    opa(1, 1, 0, 1, 9'd10, 16'h1234, 2'b01);
    mwa(10, 16'h1234, 2'b01);
    chk("R3 new data merged", 32'(do_a), 32'hBE34);
    opa(1, 0, 0, 1, 9'd10, 16'hAB00, 2'b10);
    mwa(10, 16'hAB00, 2'b10);
    opa(0, 1, 0, 1, 9'd10, 16'h0, 2'b00);
    chk("R4 high lane", 32'(do_a), 32'hAB34);
    opa(1, 0, 0, 1, 9'd10, 16'hFFFF, 2'b00);
    opa(0, 1, 0, 1, 9'd10, 16'h0, 2'b00);
    chk("R4 no lane", 32'(do_a), 32'hAB34);
    opb(1, 1, 0, 1, 11'd300, 4'h9, 2'b00);
    mdl[300*4 +: 4] = 4'h9;
    chk("R3 new data B", 32'(do_b), 32'h9);

    // R5
    opb(1, 0, 0, 1, 11'd100, 4'h7, 2'b00);
    mdl[100*4 +: 4] = 4'h7;
    opb(0, 1, 0, 1, 11'd100, 4'h0, 2'b00);
    chk("R5 be ignored", 32'(do_b), 32'h7);

    // R6
    opa(0, 1, 0, 1, 9'd20, 16'h0, 2'b00);
    chk("R6 latch", 32'(do_a), 32'(mdl[20*16 +: 16]));
    opa(0, 1, 1, 1, 9'd30, 16'h0, 2'b00);
    chk("R6 stalled read", 32'(do_a), 32'(mdl[20*16 +: 16]));
    opa(1, 0, 1, 1, 9'd31, 16'h1111, 2'b11);
    mwa(20, 16'h1111, 2'b11);
    opa(0, 1, 0, 1, 9'd20, 16'h0, 2'b00);
    chk("R6 stalled write", 32'(do_a), 32'h1111);
    opa(0, 1, 0, 1, 9'd31, 16'h0, 2'b00);
    chk("R6 untouched", 32'(do_a), 32'(mdl[31*16 +: 16]));

    // R7
    w = do_a;
    opa(1, 1, 0, 0, 9'd40, 16'hCAFE, 2'b11);
    chk("R7 output frozen", 32'(do_a), 32'(w));
    opa(0, 1, 0, 1, 9'd40, 16'h0, 2'b00);
    chk("R7 no write", 32'(do_a), 32'(mdl[40*16 +: 16]));
    opa(0, 1, 0, 1, 9'd41, 16'h0, 2'b00);
    opa(0, 1, 0, 0, 9'd42, 16'h0, 2'b00);
    opa(0, 1, 1, 1, 9'd50, 16'h0, 2'b00);
    chk("R7 address frozen", 32'(do_a), 32'(mdl[41*16 +: 16]));

    // R8
    @(negedge clk_a);
    aclr_a = 1;
    #1;
    chk("R8 async clear", 32'(do_a), 32'h0);
    @(negedge clk_a);
    aclr_a = 0;
    opa(0, 1, 0, 1, 9'd41, 16'h0, 2'b00);
    chk("R8 contents kept", 32'(do_a), 32'(mdl[41*16 +: 16]));

    // R9
    fork
      opa(1, 0, 0, 1, 9'd60, 16'h1357, 2'b11);
      opb(1, 0, 0, 1, 11'(4*61), 4'hC, 2'b00);
    join
    mwa(60, 16'h1357, 2'b11);
    mdl[4*61*4 +: 4] = 4'hC;
    fork
      opa(0, 1, 0, 1, 9'd61, 16'h0, 2'b00);
      opb(1, 0, 0, 1, 11'(4*62), 4'h5, 2'b00);
    join
    chk("R9 read beside write", 32'(do_a), 32'(mdl[61*16 +: 16]));
    mdl[4*62*4 +: 4] = 4'h5;
    opa(0, 1, 0, 1, 9'd60, 16'h0, 2'b00);
    chk("R9 both writes A", 32'(do_a), 32'h1357);
    opb(0, 1, 0, 1, 11'(4*61), 4'h0, 2'b00);
    chk("R9 both writes B", 32'(do_b), 32'hC);
    opb(0, 1, 0, 1, 11'(4*62), 4'h0, 2'b00);
    chk("R9 second write B", 32'(do_b), 32'h5);

    // R10: parity shapes
    for (int k = 0; k < 512; k++) ppa(1, 0, 9'(k), fp(k), 2'b11);
    for (int j = 0; j < 1024; j++) begin
      logic [17:0] pw;
      pw = fp(j / 2);
      ppb(10'(j));
      chk("R10 parity map", 32'(pdo_b), 32'((j % 2) ? pw[17:9] : pw[8:0]));
    end
    ppa(1, 1, 9'd3, 18'h00001, 2'b11);
    chk("R3 old data", 32'(pdo_a), 32'(fp(3)));
    ppa(0, 1, 9'd3, 18'h0, 2'b00);
    chk("R3 old mode written", 32'(pdo_a), 32'h1);
    ppa(1, 0, 9'd5, 18'h3FFFF, 2'b01);
    ppa(0, 1, 9'd5, 18'h0, 2'b00);
    chk("R4 nine-bit lane", 32'(pdo_a), 32'({fp(5)[17:9], 9'h1FF}));
    ppb(10'd10);
    chk("R10 lane seen by B", 32'(pdo_b), 32'h1FF);

    done = 1'b1;
    finish_up();
  end

endmodule